// File: doc/BRIEF.md
# Flash Busy and Toggle-Status Generator

This block produces the status a NOR-style flash part shows to a host while an embedded program or erase runs. A one-cycle strobe marks the closing write-enable edge of a command. That strobe carries the operation kind and a flag saying whether every targeted sector is protected. From the same clock edge onward, the block pulls its ready/busy line low. Every read strobe then returns a status word in which bit 6 flips from one read to the next.

When the operation finishes, the busy line is released and reads return the array word presented on an input port. The durations are parameters in clock cycles:

- a normal program;
- the post-command erase time-out window;
- the erase body;
- the short toggle window of a program aimed at a protected sector;
- the longer toggle window of an erase whose sectors are all protected.

An erase can be suspended, can take one program while suspended, and can then be resumed. It continues with the cycles it had left.

The ready/busy pin is open-drain. It is brought out as a pull-low enable, and the board resolves the pull-up.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the pull-low enable is 0, and a read returns `array_data` as it was at the read strobe.
- R2: A `cmd_done` sampled while idle sets `busy_pull_low` to 1 from that same clock edge, and it stays 1 for the whole operation.
- R3: While an operation is toggling, a read returns a word with bit 6 as its only possibly-set bit. Bit 6 is the inverse of the previous toggling read. `rd_data` is updated one clock after the `rd_strobe` edge and then holds.
- R4: A normal program toggles for exactly `PROG_CYC` read edges after the command edge. From the following edge, busy is released and reads return `array_data`.
- R5: A program to a protected target toggles for `PROT_PROG_CYC` edges, and an erase whose targets are all protected toggles for `PROT_ERASE_CYC` edges. Busy is held during that window. Afterwards reads return `array_data`.
- R6: An unprotected erase toggles and holds busy through the time-out window of `ETO_CYC` edges. It then continues for `ERASE_CYC` edges, for a total of `ETO_CYC+ERASE_CYC`.
- R7: `susp_req` during the erase body enters suspend from the next edge. In suspend busy is released, and reads return `array_data` without advancing bit 6.
- R8: In suspend, a program command (`op_erase`=0) holds busy and toggles for its duration, then returns to suspend with busy released.
- R9: `resume_req` in suspend holds busy again at once. Toggling resumes, and the erase ends after the cycles it had left.
- R10: Four inputs are ignored:
  - a command while busy;
  - an erase command in suspend;
  - `susp_req` outside the erase body;
  - `resume_req` outside suspend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_done | input | 1 | One-cycle strobe: closing write-enable edge of a command |
| op_erase | input | 1 | 1 = erase, 0 = program, qualified by `cmd_done` |
| tgt_protected | input | 1 | All targeted sectors protected, qualified by `cmd_done` |
| susp_req | input | 1 | Erase suspend request strobe |
| resume_req | input | 1 | Erase resume request strobe |
| rd_strobe | input | 1 | Read access strobe (output-enable or chip-enable pulse) |
| array_data | input | DATA_W | Array word returned outside toggling operations |
| rd_data | output | DATA_W | Registered read result |
| busy_pull_low | output | 1 | Open-drain pull-down enable, 1 = busy |

## Verification
A wrong sequencer state shows at the ports by the next read strobe, or sooner on the pull-low enable. Such a state would be, for example, a missed time-out-to-erase hand-off or suspend taken in the wrong phase. The symptom is either a status word where array data was due, or array data where bit 6 should have flipped. A counter that is off by one moves the last toggling read by one edge. For that reason, each duration is probed with reads on exactly its final active edge and on the first idle edge after it. A toggle flop that advances on the wrong reads surfaces as two equal bit-6 values on consecutive toggling reads.

// File: rtl/flsts_pkg.sv
// Shared definitions for the flash status generator: sequencer states,
// position of the toggling status bit, and state classification helpers.
package flsts_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PROG  = 3'd1,
        ST_ETO   = 3'd2,
        ST_ERASE = 3'd3,
        ST_PROT  = 3'd4,
        ST_SUSP  = 3'd5,
        ST_SPROG = 3'd6
    } fl_state_e;

    localparam int TOG_POS = 6;

    // True in every state where an embedded algorithm runs (busy and toggling).
    function automatic logic is_running(input fl_state_e s);
        return (s == ST_PROG) || (s == ST_ETO) || (s == ST_ERASE) ||
               (s == ST_PROT) || (s == ST_SPROG);
    endfunction

endpackage

// File: rtl/flsts_timer.sv
// Down-counter timing the current phase. Load takes priority over restore,
// and restore over the free-running decrement. A save copies the live count
// into a holding register so a suspended erase can continue later.
// Assumes load and restore are never requested together.
module flsts_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             save,
    input  logic             restore,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] held;

    // Phase count: reload, restore from hold, or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (restore) begin
            cnt <= held;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // Holding register for the remaining erase count across a suspend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
        end else if (save) begin
            held <= cnt;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/flsts_seq.sv
// Operation sequencer. Decides the phase (program, erase time-out, erase
// body, protected toggle window, suspend, program-in-suspend) and drives the
// phase timer. A loaded count of N-1 gives N active clock edges.
// Assumes every duration parameter is at least 1.
module flsts_seq
    import flsts_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int PROG_CYC       = 1000,
    parameter int ETO_CYC        = 6250,
    parameter int ERASE_CYC      = 100000,
    parameter int PROT_PROG_CYC  = 125,
    parameter int PROT_ERASE_CYC = 12500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_done,
    input  logic             op_erase,
    input  logic             tgt_protected,
    input  logic             susp_req,
    input  logic             resume_req,
    input  logic             expired,
    output fl_state_e        state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             tmr_save,
    output logic             tmr_restore
);

    localparam logic [CNT_W-1:0] PROG_V  = CNT_W'(PROG_CYC - 1);
    localparam logic [CNT_W-1:0] ETO_V   = CNT_W'(ETO_CYC - 1);
    localparam logic [CNT_W-1:0] ERASE_V = CNT_W'(ERASE_CYC - 1);
    localparam logic [CNT_W-1:0] PP_V    = CNT_W'(PROT_PROG_CYC - 1);
    localparam logic [CNT_W-1:0] PE_V    = CNT_W'(PROT_ERASE_CYC - 1);

    fl_state_e nxt;

    // Next-phase decision and timer control for the current phase.
    always_comb begin
        nxt         = state;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        tmr_save    = 1'b0;
        tmr_restore = 1'b0;
        case (state)
            ST_IDLE: begin
                if (cmd_done) begin
                    tmr_load = 1'b1;
                    if (tgt_protected) begin
                        nxt     = ST_PROT;
                        tmr_val = op_erase ? PE_V : PP_V;
                    end else if (op_erase) begin
                        nxt     = ST_ETO;
                        tmr_val = ETO_V;
                    end else begin
                        nxt     = ST_PROG;
                        tmr_val = PROG_V;
                    end
                end
            end
            ST_PROG, ST_PROT: begin
                if (expired) nxt = ST_IDLE;
            end
            ST_ETO: begin
                if (expired) begin
                    nxt      = ST_ERASE;
                    tmr_load = 1'b1;
                    tmr_val  = ERASE_V;
                end
            end
            ST_ERASE: begin
                if (susp_req) begin
                    nxt      = ST_SUSP;
                    tmr_save = 1'b1;
                end else if (expired) begin
                    nxt = ST_IDLE;
                end
            end
            ST_SUSP: begin
                if (resume_req) begin
                    nxt         = ST_ERASE;
                    tmr_restore = 1'b1;
                end else if (cmd_done && !op_erase) begin
                    nxt      = ST_SPROG;
                    tmr_load = 1'b1;
                    tmr_val  = tgt_protected ? PP_V : PROG_V;
                end
            end
            ST_SPROG: begin
                if (expired) nxt = ST_SUSP;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

endmodule

// File: rtl/flsts_rdout.sv
// Read-return path. On each read strobe it registers either the status word
// (bit TOG_POS = toggle flop, other bits zero) or the array word, and it
// inverts the toggle flop after every read taken while an operation runs.
// Assumes DATA_W > TOG_POS.
module flsts_rdout
    import flsts_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_strobe,
    input  logic              running,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data
);

    logic              tog_q;
    logic [DATA_W-1:0] status_w;

    // Status word: only the toggle bit may be set.
    always_comb begin
        status_w          = '0;
        status_w[TOG_POS] = tog_q;
    end

    // Toggle flop: flips on each read that lands during an operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tog_q <= 1'b0;
        else if (rd_strobe && running)  tog_q <= ~tog_q;
    end

    // Read data register: captured at the read strobe, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_data <= '0;
        else if (rd_strobe) rd_data <= running ? status_w : array_data;
    end

endmodule

// File: rtl/flash_status_gen.sv
// Top of the flash status generator. It combines the sequencer, the phase
// timer and the read-return path, and it drives the open-drain ready/busy
// line as a pull-low enable. Assumes single-cycle strobes on the synchronous
// inputs, and that the duration parameters are all at least 1.
module flash_status_gen
    import flsts_pkg::*;
#(
    parameter int DATA_W         = 16,
    parameter int PROG_CYC       = 1000,
    parameter int ETO_CYC        = 6250,
    parameter int ERASE_CYC      = 100000,
    parameter int PROT_PROG_CYC  = 125,
    parameter int PROT_ERASE_CYC = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_done,
    input  logic              op_erase,
    input  logic              tgt_protected,
    input  logic              susp_req,
    input  logic              resume_req,
    input  logic              rd_strobe,
    input  logic [DATA_W-1:0] array_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy_pull_low
);

    localparam int MAX_A   = (PROG_CYC > ETO_CYC) ? PROG_CYC : ETO_CYC;
    localparam int MAX_B   = (ERASE_CYC > PROT_PROG_CYC) ? ERASE_CYC : PROT_PROG_CYC;
    localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_CYC = (MAX_C > PROT_ERASE_CYC) ? MAX_C : PROT_ERASE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    fl_state_e        seq_state;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_save;
    logic             tmr_restore;
    logic             tmr_expired;
    logic             running;

    flsts_seq #(
        .CNT_W         (CNT_W),
        .PROG_CYC      (PROG_CYC),
        .ETO_CYC       (ETO_CYC),
        .ERASE_CYC     (ERASE_CYC),
        .PROT_PROG_CYC (PROT_PROG_CYC),
        .PROT_ERASE_CYC(PROT_ERASE_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_done     (cmd_done),
        .op_erase     (op_erase),
        .tgt_protected(tgt_protected),
        .susp_req     (susp_req),
        .resume_req   (resume_req),
        .expired      (tmr_expired),
        .state        (seq_state),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .tmr_save     (tmr_save),
        .tmr_restore  (tmr_restore)
    );

    flsts_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .save    (tmr_save),
        .restore (tmr_restore),
        .expired (tmr_expired)
    );

    // Busy and toggling share one definition: an embedded algorithm is running.
    assign running       = is_running(seq_state);
    assign busy_pull_low = running;

    flsts_rdout #(
        .DATA_W(DATA_W)
    ) u_rdout (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_strobe (rd_strobe),
        .running   (running),
        .array_data(array_data),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/flsts_chk.sv
// Assertion checker for flash_status_gen. It watches the ports and the
// sequencer phase, and it keeps its own copy of the last toggling bit 6.
module flsts_chk
    import flsts_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_done,
    input logic              susp_req,
    input logic              rd_strobe,
    input logic [DATA_W-1:0] array_data,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy_pull_low,
    input fl_state_e         st
);

    logic pend_act;
    logic have_prev;
    logic prev_b6;

    // Track toggling reads: remember bit 6 once each such read has landed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_act  <= 1'b0;
            have_prev <= 1'b0;
            prev_b6   <= 1'b0;
        end else begin
            pend_act <= rd_strobe && busy_pull_low;
            if (pend_act) begin
                have_prev <= 1'b1;
                prev_b6   <= rd_data[TOG_POS];
            end
        end
    end

    AST_IDLE_CMD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cmd_done) |=> busy_pull_low);                                  // R2

    AST_STATUS_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && busy_pull_low) |=> ((rd_data & ~(DATA_W'(1) << TOG_POS)) == '0));  // R3

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_act && have_prev) |-> (rd_data[TOG_POS] != prev_b6));                      // R3

    AST_READY_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !busy_pull_low) |=> (rd_data == $past(array_data)));               // R4

    AST_SUSP_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SUSP) |-> !busy_pull_low);                                              // R7

    AST_NO_EARLY_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == ST_PROG || st == ST_ETO) && susp_req) |=> (st != ST_SUSP));              // R10

endmodule

bind flash_status_gen flsts_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_done     (cmd_done),
    .susp_req     (susp_req),
    .rd_strobe    (rd_strobe),
    .array_data   (array_data),
    .rd_data      (rd_data),
    .busy_pull_low(busy_pull_low),
    .st           (seq_state)
);

// File: tb/flash_status_gen_tb.sv
// Scoreboard bench: read tasks push the expected word, and a monitor pops and
// compares it when the registered result appears.
module flash_status_gen_tb;

    localparam int DW  = 16;
    localparam int PC  = 10;
    localparam int EC  = 6;
    localparam int ERC = 40;
    localparam int PPC = 4;
    localparam int PEC = 12;

    typedef struct {
        logic [DW-1:0] val;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_done = 1'b0;
    logic          op_erase = 1'b0;
    logic          tgt_protected = 1'b0;
    logic          susp_req = 1'b0;
    logic          resume_req = 1'b0;
    logic          rd_strobe = 1'b0;
    logic [DW-1:0] array_data = '0;
    logic [DW-1:0] rd_data;
    logic          busy_pull_low;
    logic          rdy_line;

    int   n_chk = 0;
    int   n_err = 0;
    logic exp_tog = 1'b0;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    flash_status_gen #(
        .DATA_W(DW), .PROG_CYC(PC), .ETO_CYC(EC), .ERASE_CYC(ERC),
        .PROT_PROG_CYC(PPC), .PROT_ERASE_CYC(PEC)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .op_erase(op_erase),
        .tgt_protected(tgt_protected), .susp_req(susp_req), .resume_req(resume_req),
        .rd_strobe(rd_strobe), .array_data(array_data), .rd_data(rd_data),
        .busy_pull_low(busy_pull_low)
    );

    // Open-drain line with board pull-up.
    assign rdy_line = busy_pull_low ? 1'b0 : 1'b1;

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_rdy(input logic exp, input string tag);
        n_chk++;
        if (rdy_line !== exp) begin
            n_err++;
            $display("FAIL %s ready line act=%b exp=%b", tag, rdy_line, exp);
        end
    endtask

    task automatic do_read(input bit act, input string tag);
        exp_t e;
        if (act) begin
            e.val = '0;
            e.val[6] = exp_tog;
            exp_tog = ~exp_tog;
        end else begin
            e.val = array_data;
        end
        e.tag = tag;
        exp_q.push_back(e);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic do_cmd(input logic erase, input logic prot);
        cmd_done = 1'b1; op_erase = erase; tgt_protected = prot;
        @(negedge clk);
        cmd_done = 1'b0; op_erase = 1'b0; tgt_protected = 1'b0;
    endtask

    task automatic pulse_susp();
        susp_req = 1'b1;
        @(negedge clk);
        susp_req = 1'b0;
    endtask

    task automatic pulse_resume();
        resume_req = 1'b1;
        @(negedge clk);
        resume_req = 1'b0;
    endtask

    // Monitor: compare the registered read result against the scoreboard.
    always @(posedge clk) begin
        if (rd_strobe) begin
            #2;
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL scoreboard empty act=%h exp=none", rd_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rd_data !== e.val) begin
                    n_err++;
                    $display("FAIL %s read act=%h exp=%h", e.tag, rd_data, e.val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog act=running exp=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        array_data = 16'hA5C3;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // R1: reset state
        chk_rdy(1'b1, "R1");
        do_read(1'b0, "R1");

        // R2/R3/R4: normal program and its exact end
        do_cmd(1'b0, 1'b0);
        chk_rdy(1'b0, "R2");
        do_read(1'b1, "R3");
        do_read(1'b1, "R3");
        do_read(1'b1, "R3");
        wait_cyc(PC - 4);
        chk_rdy(1'b0, "R2");
        do_read(1'b1, "R4 last edge");
        chk_rdy(1'b1, "R4");
        do_read(1'b0, "R4 first idle");
        array_data = 16'h1234;
        do_read(1'b0, "R4 new array");

        // R5: protected program window
        do_cmd(1'b0, 1'b1);
        chk_rdy(1'b0, "R5");
        do_read(1'b1, "R5");
        wait_cyc(PPC - 2);
        do_read(1'b1, "R5 last edge");
        do_read(1'b0, "R5 idle");

        // R6: erase with time-out window
        do_cmd(1'b1, 1'b0);
        chk_rdy(1'b0, "R6");
        do_read(1'b1, "R6 time-out");
        wait_cyc(EC + ERC - 2);
        chk_rdy(1'b0, "R6");
        do_read(1'b1, "R6 last edge");
        do_read(1'b0, "R6 idle");

        // R5: all-protected erase window
        do_cmd(1'b1, 1'b1);
        do_read(1'b1, "R5 erase");
        wait_cyc(PEC - 2);
        do_read(1'b1, "R5 erase last");
        do_read(1'b0, "R5 erase idle");
        chk_rdy(1'b1, "R5");

        // R7..R9: suspend, program in suspend, resume
        do_cmd(1'b1, 1'b0);
        wait_cyc(14);
        pulse_susp();
        chk_rdy(1'b1, "R7");
        do_read(1'b0, "R7");
        do_read(1'b0, "R7");
        do_cmd(1'b1, 1'b0);
        chk_rdy(1'b1, "R10 erase in suspend");
        do_read(1'b0, "R10 erase in suspend");
        do_cmd(1'b0, 1'b0);
        chk_rdy(1'b0, "R8");
        do_read(1'b1, "R8");
        do_read(1'b1, "R8");
        wait_cyc(PC + 2);
        chk_rdy(1'b1, "R8");
        do_read(1'b0, "R8 back in suspend");
        pulse_resume();
        chk_rdy(1'b0, "R9");
        do_read(1'b1, "R9");
        wait_cyc(ERC + 5);
        chk_rdy(1'b1, "R9");
        do_read(1'b0, "R9 done");

        // R10: commands and suspend ignored while programming
        do_cmd(1'b0, 1'b0);
        do_cmd(1'b1, 1'b0);
        pulse_susp();
        chk_rdy(1'b0, "R10");
        do_read(1'b1, "R10");
        wait_cyc(PC - 4);
        do_read(1'b1, "R10 last edge");
        do_read(1'b0, "R10 idle");
        pulse_resume();
        chk_rdy(1'b1, "R10 resume idle");
        do_read(1'b0, "R10 resume idle");

        wait_cyc(2);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule